// File: doc/BRIEF.md
# Context Model Store with Pipelined Bin Sequencer

This block holds the probability models used by a binary arithmetic entropy decoder and schedules one bin decode per request from a host processor. Each context entry is a 6-bit probability state plus a most-probable-symbol bit. All entries sit in a dual-port RAM, so one address can be read while another is written in the same cycle.

The block is idle after reset. When a slice starts, a sequencer walks every context address, one write per cycle. Each write takes a value from an initialization table selected by the slice quantizer. The sequencer also sends a one-cycle initialization pulse to the arithmetic engine. After that, requests carrying a context index and a decode mode flow through a two-stage pipeline:
- **Pre-decode stage.** Runs in the cycle the request is accepted and issues the RAM read.
- **Decode stage.** Runs in the following cycle. It presents the context to an external arithmetic engine and writes the engine's updated state back.

A new request can be read while the previous one is written back. A one-entry forwarding register covers the case where two back-to-back bins use the same context. The request side is valid/ready. The result side is a plain done pulse with no back-pressure, so the consumer must take every result in the cycle it appears.

Top module: `cabac_ctx_seq`

## Requirements
- R1: After reset, `busy`, `req_ready`, `eng_fire`, `eng_init` and `res_valid` are low, and the block stays idle until `slice_start` is seen.
- R2: When `slice_start` is high in a cycle where `busy` is low, `busy` is high for exactly NUM_CTX (459) consecutive cycles starting in the next cycle, `eng_init` is high only in the first of them, and `req_ready` is high in the cycle after `busy` falls.
- R3: Initialization loads entry i with state = (i + qp) mod 64 and MPS = bit 6 of (i + qp), where qp is `slice_qp` sampled with `slice_start`.
- R4: `req_ready` is low while idle, while `busy` is high, and in any cycle where `slice_start` is high. A request offered then is not taken and produces no result.
- R5: A request accepted in cycle c (`req_valid` and `req_ready` both high) raises `eng_fire` in cycle c+1 with `eng_mode` equal to its mode. It raises `res_valid` in cycle c+2, with `res_bin` equal to the `eng_bin` seen in cycle c+1.
- R6: For a regular request (mode 0), `eng_state`/`eng_mps` in the decode cycle show the entry's current value. `eng_new_state`/`eng_new_mps` in that cycle become the entry's new value.
- R7: Regular requests may be accepted in every cycle. When consecutive requests use the same index, each one sees the value written back by the one before it.
- R8: Modes 1 (bypass), 2 (terminate) and 3 (reserved, handled as bypass) neither read nor modify the context RAM. During their decode cycle, `eng_state` and `eng_mps` are zero.
- R9: Exactly one result is produced per accepted request, in acceptance order.
- R10: A new `slice_start` while running overwrites every entry with the values for the new qp, replacing any earlier updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_start | input | 1 | Starts context initialization |
| slice_qp | input | 6 | Quantizer selecting initial values, sampled with slice_start |
| busy | output | 1 | Initialization in progress |
| eng_init | output | 1 | One-cycle pulse asking the engine to reset its interval |
| req_valid | input | 1 | Bin request offered |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_ctx | input | 9 | Context index, below NUM_CTX |
| req_mode | input | 2 | 0 regular, 1 bypass, 2 terminate, 3 treated as bypass |
| eng_fire | output | 1 | Decode cycle for the engine |
| eng_mode | output | 2 | Mode of the bin being decoded |
| eng_state | output | 6 | Current probability state (zero if not regular) |
| eng_mps | output | 1 | Current MPS (zero if not regular) |
| eng_bin | input | 1 | Engine's decoded bin, same cycle |
| eng_new_state | input | 6 | Engine's updated state, same cycle |
| eng_new_mps | input | 1 | Engine's updated MPS, same cycle |
| res_valid | output | 1 | Done pulse for one bin |
| res_bin | output | 1 | Decoded bin value |

## Verification
The assertions assume that `req_ctx` is below NUM_CTX whenever `req_valid` is high. They also assume the engine answers combinationally within the decode cycle, and that `slice_start` is a single-cycle pulse. The stimulus draws indices only from that range. Its engine model returns results from the same-cycle `eng_*` outputs, and it raises `slice_start` for one cycle at a time. The bench holds a request during initialization so that the refusal path is exercised without breaking any of these assumptions.

// File: rtl/cabac_ctx_pkg.sv
package cabac_ctx_pkg;
  localparam int STATE_W = 6;

  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_BYP = 2'd1,
    MODE_TRM = 2'd2,
    MODE_RSV = 2'd3
  } bin_mode_e;

  typedef struct packed {
    logic               mps;
    logic [STATE_W-1:0] state;
  } ctx_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_INIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/ctx_init_rom.sv
module ctx_init_rom
  import cabac_ctx_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int QP_W  = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [QP_W-1:0]  qp,
  output ctx_t             ctx
);
  localparam int SUM_W = STATE_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum       = SUM_W'(idx) + SUM_W'(qp);
    ctx.state = sum[STATE_W-1:0];
    ctx.mps   = sum[STATE_W];
  end
endmodule

// File: rtl/ctx_ram.sv
module ctx_ram
  import cabac_ctx_pkg::*;
#(
  parameter int DEPTH = 459,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  ctx_t             wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output ctx_t             rdata
);
  ctx_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) assert_waddr_range_R3: assert (int'(waddr) < DEPTH);
    if (re) assert_raddr_range_R6: assert (int'(raddr) < DEPTH);
  end
endmodule

// File: rtl/ctx_init_seq.sv
module ctx_init_seq
  import cabac_ctx_pkg::*;
#(
  parameter int NUM_CTX = 459,
  parameter int IDX_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slice_start,
  output logic             busy,
  output logic             run,
  output logic             first,
  output logic [IDX_W-1:0] addr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CTX - 1);

  seq_st_e          st;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SEQ_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SEQ_INIT: begin
          if (cnt == LAST) st <= SEQ_RUN;
          else             cnt <= cnt + 1'b1;
        end
        default: begin
          if (slice_start) begin
            st  <= SEQ_INIT;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    busy  = (st == SEQ_INIT);
    run   = (st == SEQ_RUN);
    first = busy && (cnt == '0);
    addr  = cnt;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
  assert_init_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> (run && !busy));
  assert_start_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_start && !busy) |=> (busy && first));
endmodule

// File: rtl/cabac_ctx_seq.sv
module cabac_ctx_seq
  import cabac_ctx_pkg::*;
#(
  parameter int NUM_CTX = 459,
  parameter int QP_W    = 6,
  parameter int IDX_W   = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slice_start,
  input  logic [QP_W-1:0]    slice_qp,
  output logic               busy,
  output logic               eng_init,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_ctx,
  input  logic [1:0]         req_mode,
  output logic               eng_fire,
  output logic [1:0]         eng_mode,
  output logic [STATE_W-1:0] eng_state,
  output logic               eng_mps,
  input  logic               eng_bin,
  input  logic [STATE_W-1:0] eng_new_state,
  input  logic               eng_new_mps,
  output logic               res_valid,
  output logic               res_bin
);
  // sequencer
  logic             run, init_first;
  logic [IDX_W-1:0] init_addr;
  logic [QP_W-1:0]  qp_q;

  ctx_init_seq #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .slice_start(slice_start),
    .busy(busy), .run(run), .first(init_first), .addr(init_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   qp_q <= '0;
    else if (slice_start && !busy) qp_q <= slice_qp;
  end

  ctx_t rom_ctx;
  ctx_init_rom #(.IDX_W(IDX_W), .QP_W(QP_W)) rom_i (
    .idx(init_addr), .qp(qp_q), .ctx(rom_ctx)
  );

  // pre-decode stage
  logic      accept;
  bin_mode_e in_mode;

  always_comb begin
    in_mode   = bin_mode_e'(req_mode);
    req_ready = run && !slice_start;
    accept    = req_valid && req_ready;
    eng_init  = init_first;
  end

  // decode stage registers
  logic             s2_valid;
  logic [IDX_W-1:0] s2_idx;
  bin_mode_e        s2_mode;
  logic             s2_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_idx   <= '0;
      s2_mode  <= MODE_REG;
    end else begin
      s2_valid <= accept;
      if (accept) begin
        s2_idx  <= req_ctx;
        s2_mode <= in_mode;
      end
    end
  end

  // forwarding of the previous write-back
  logic             fwd_valid;
  logic [IDX_W-1:0] fwd_idx;
  ctx_t             fwd_ctx;
  ctx_t             ram_rdata, cur_ctx, wb_ctx;
  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  ctx_t             ram_wdata;

  always_comb begin
    s2_reg       = s2_valid && (s2_mode == MODE_REG);
    cur_ctx      = (fwd_valid && fwd_idx == s2_idx) ? fwd_ctx : ram_rdata;
    wb_ctx.state = eng_new_state;
    wb_ctx.mps   = eng_new_mps;
    eng_fire     = s2_valid;
    eng_mode     = s2_mode;
    eng_state    = s2_reg ? cur_ctx.state : '0;
    eng_mps      = s2_reg ? cur_ctx.mps : 1'b0;
    ram_we       = busy || s2_reg;
    ram_waddr    = busy ? init_addr : s2_idx;
    ram_wdata    = busy ? rom_ctx : wb_ctx;
  end

  ctx_ram #(.DEPTH(NUM_CTX), .IDX_W(IDX_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(accept && in_mode == MODE_REG), .raddr(req_ctx), .rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_idx   <= '0;
      fwd_ctx   <= '0;
      res_valid <= 1'b0;
      res_bin   <= 1'b0;
    end else begin
      fwd_valid <= s2_reg && !busy;
      fwd_idx   <= s2_idx;
      fwd_ctx   <= wb_ctx;
      res_valid <= s2_valid;
      if (s2_valid) res_bin <= eng_bin;
    end
  end

  // checks
  assert_ctx_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_ctx) < NUM_CTX));
  assert_no_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (!busy && !slice_start));
  assert_fire_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (eng_fire && eng_mode == $past(req_mode)));
  assert_done_after_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fire |=> (res_valid && res_bin == $past(eng_bin)));
  assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_fire |=> !res_valid);
  assert_wb_regular_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 2'd0) |=> ram_we);
  assert_no_wb_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode != 2'd0) |=> !ram_we);
  assert_same_ctx_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_fire && eng_mode == 2'd0 && $past(eng_fire && eng_mode == 2'd0)
     && s2_idx == $past(s2_idx))
    |-> (eng_state == $past(eng_new_state) && eng_mps == $past(eng_new_mps)));
  assert_init_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_init |-> busy);
endmodule

// File: tb/cabac_ctx_seq_tb_top.sv
`timescale 1ns/1ps
module cabac_ctx_seq_tb_top;
  localparam int NUM_CTX = 459;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slice_start = 1'b0;
  logic [5:0] slice_qp = '0;
  logic       busy, eng_init, req_ready, eng_fire, eng_mps, res_valid, res_bin;
  logic       req_valid = 1'b0;
  logic [8:0] req_ctx = '0;
  logic [1:0] req_mode = '0;
  logic [1:0] eng_mode;
  logic [5:0] eng_state;
  logic       eng_bin, eng_new_mps;
  logic [5:0] eng_new_state;

  always #2 clk = ~clk;

  cabac_ctx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .slice_start(slice_start), .slice_qp(slice_qp),
    .busy(busy), .eng_init(eng_init), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_mode(req_mode), .eng_fire(eng_fire), .eng_mode(eng_mode),
    .eng_state(eng_state), .eng_mps(eng_mps), .eng_bin(eng_bin),
    .eng_new_state(eng_new_state), .eng_new_mps(eng_new_mps),
    .res_valid(res_valid), .res_bin(res_bin)
  );

  // engine model: regular bins advance the state, flipping MPS past 63
  always_comb begin
    if (eng_mode == 2'd0) begin
      eng_bin       = eng_mps ^ eng_state[0];
      eng_new_state = eng_state + 6'd1;
      eng_new_mps   = eng_mps ^ (eng_state == 6'd63);
    end else begin
      eng_bin       = (eng_mode == 2'd2) ? !(eng_state == 0 && !eng_mps)
                                         : (eng_state == 0 && !eng_mps);
      eng_new_state = 6'h2a;
      eng_new_mps   = 1'b1;
    end
  end

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // reference model and scoreboards
  logic [5:0] m_state [NUM_CTX];
  logic       m_mps   [NUM_CTX];
  int  f_cyc [512]; logic [1:0] f_mode [512]; logic [5:0] f_st [512]; logic f_mp [512];
  int  r_cyc [512]; logic r_bin [512];
  int  wp = 0, frp = 0, rrp = 0;

  task automatic model_init(input int qp);
    for (int i = 0; i < NUM_CTX; i++) begin
      m_state[i] = 6'((i + qp) % 64);
      m_mps[i]   = ((i + qp) >> 6) & 1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && eng_fire) begin
      if (frp == wp) chk(0, "R5", "unexpected eng_fire", 1, 0);
      else begin
        chk(cyc == f_cyc[frp], "R5", "fire cycle", cyc, f_cyc[frp]);
        chk(eng_mode == f_mode[frp], "R5", "eng_mode", eng_mode, f_mode[frp]);
        chk(eng_state == f_st[frp], f_mode[frp] == 0 ? "R6" : "R8", "eng_state",
            eng_state, f_st[frp]);
        chk(eng_mps == f_mp[frp], f_mode[frp] == 0 ? "R6" : "R8", "eng_mps",
            eng_mps, f_mp[frp]);
        frp = (frp + 1) % 512;
      end
    end
    if (rst_n && res_valid) begin
      if (rrp == wp) chk(0, "R9", "unexpected res_valid", 1, 0);
      else begin
        chk(cyc == r_cyc[rrp], "R5", "result cycle", cyc, r_cyc[rrp]);
        chk(res_bin == r_bin[rrp], "R9", "res_bin", res_bin, r_bin[rrp]);
        rrp = (rrp + 1) % 512;
      end
    end
  end

  task automatic issue(input int idx, input logic [1:0] mode);
    @(negedge clk);
    req_valid = 1'b1; req_ctx = 9'(idx); req_mode = mode;
    #1;
    chk(req_ready, "R7", "ready in run", req_ready, 1);
    f_cyc[wp] = cyc + 1;
    r_cyc[wp] = cyc + 2;
    f_mode[wp] = mode;
    if (mode == 2'd0) begin
      f_st[wp] = m_state[idx]; f_mp[wp] = m_mps[idx];
      r_bin[wp] = m_mps[idx] ^ m_state[idx][0];
      m_mps[idx] = m_mps[idx] ^ (m_state[idx] == 6'd63);
      m_state[idx] = m_state[idx] + 6'd1;
    end else begin
      f_st[wp] = '0; f_mp[wp] = 1'b0;
      r_bin[wp] = (mode != 2'd2);
    end
    wp = (wp + 1) % 512;
  endtask

  task automatic idle(input int n);
    @(negedge clk); req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    idle(4);
    chk(rrp == wp && frp == wp, "R9", {"all results returned ", tag}, rrp, wp);
  endtask

  task automatic do_init(input int qp, input bit hold_req);
    int n = 0;
    @(negedge clk);
    slice_start = 1'b1; slice_qp = 6'(qp);
    req_valid = hold_req; req_ctx = 9'd7; req_mode = 2'd0;
    #1 chk(!req_ready, "R4", "ready with slice_start", req_ready, 0);
    @(negedge clk);
    slice_start = 1'b0;
    chk(eng_init, "R2", "eng_init first cycle", eng_init, 1);
    while (busy) begin
      if (n == 1) chk(!eng_init, "R2", "eng_init one cycle", eng_init, 0);
      if (!req_ready == 0) chk(0, "R4", "ready during init", req_ready, 0);
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(n == NUM_CTX, "R2", "busy length", n, NUM_CTX);
    chk(req_ready, "R2", "ready after init", req_ready, 1);
    model_init(qp);
  endtask

  task automatic t_reset();
    chk(!busy && !req_ready && !eng_fire && !eng_init && !res_valid, "R1",
        "outputs after reset", {busy, req_ready, eng_fire, res_valid}, 0);
    @(negedge clk); req_valid = 1'b1; req_ctx = 9'd3;
    repeat (3) begin
      #1 chk(!req_ready, "R4", "ready while idle", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(!busy, "R1", "still idle", busy, 0);
    drained("R4 idle");
  endtask

  task automatic t_init_values();
    issue(0, 2'd0); idle(2);
    issue(458, 2'd0); idle(1);
    issue(200, 2'd0); issue(63, 2'd0);
    drained("R3");
  endtask

  task automatic t_same_ctx();
    for (int k = 0; k < 10; k++) issue(7, 2'd0);
    for (int k = 0; k < 4; k++) issue(49, 2'd0);
    drained("R7");
  endtask

  task automatic t_alternate();
    for (int k = 0; k < 6; k++) begin issue(3, 2'd0); issue(4, 2'd0); end
    issue(10, 2'd0); idle(0); issue(10, 2'd0); idle(1); issue(10, 2'd0);
    drained("R7 gaps");
  endtask

  task automatic t_non_regular();
    issue(3, 2'd0); issue(3, 2'd1); issue(3, 2'd2); issue(3, 2'd3);
    issue(3, 2'd0); issue(5, 2'd1); issue(5, 2'd0);
    drained("R8");
  endtask

  task automatic t_reinit();
    do_init(40, 1'b1);
    issue(7, 2'd0); issue(49, 2'd0); issue(3, 2'd0); issue(458, 2'd0);
    drained("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_init(13, 1'b0);
    t_init_values();
    t_same_ctx();
    t_alternate();
    t_non_regular();
    t_reinit();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule